// File: doc/BRIEF.md
# Serial Calendar Clock Device

This block is the device end of a three-wire calendar clock link. A host drives a data line, a shift clock and a strobe, and reads one data-return line. Everything inside runs on one system clock, and the three serial inputs are sampled on it. The block keeps a running time of day and date. That time advances once for each pulse on a one-second enable input.

The host talks to the block through a single 52-stage chain:

- **Command stage.** Serial data enters a 4-stage command stage first. The 4 bits sent before a strobe form a command, least significant bit first. The strobe runs that command.
- **Time register.** The oldest command bit feeds the top of a 48-bit time register. The lowest bit of that register drives the data-return line.
- **Reading.** A read command copies the running time into the register. After a shift command, the host can clock the fields out.
- **Writing.** To load a new time, the host enters shift mode and sends 48 data bits. It then sends a set command. The 4 bits of that set command push the data the last 4 places into alignment. The strobe then copies the register into the running time and holds the counter until the next strobe.

Top module: `serial_calendar`

## Requirements
- R1: After synchronous reset, `ser_dout` is 0. The running time is 00:00:00, day 01, month 1, weekday 0, year 00, and a read returns exactly that word.
- R2: On each rising edge of `ser_sclk`, `ser_din` enters the command stage, least significant bit first. A rising edge of `ser_stb` runs the 4 bits last entered. The codes are: 0 freezes the register, 1 enables shifting, 2 loads the running time, and 3 copies the running time out.
- R3: While shift mode is active, each `ser_sclk` rise moves the whole chain by one place. The oldest command bit enters register bit 47, and `ser_dout` always shows register bit 0.
- R4: The register layout is:
  - bits 7:0 hold seconds, 15:8 minutes, 23:16 hours and 31:24 day of month, all in BCD;
  - bits 35:32 hold the weekday as 0 to 6;
  - bits 39:36 hold the month in binary as 1 to 12;
  - bits 47:40 hold a two-digit BCD year.
- R5: A strobe with code 3 copies the running time into the register, which a following shift-out returns unchanged.
- R6: A strobe with code 2 copies the register into the running time. After that, one-second pulses have no effect until the next strobe.
- R7: In any mode other than shift, `ser_sclk` edges leave the time register unchanged.
- R8: Each one-second pulse adds one second. Seconds wrap after 59 into minutes, minutes wrap after 59 into hours, and hours wrap after 23 into a day step. Without a pulse, the time does not change.
- R9: The day wraps after the last day of the month: 30 for months 4, 6, 9 and 11; 31 for the other months other than February; and 28 for February, or 29 when the BCD year is divisible by 4 (including 00). Month 12 wraps to 1 and carries into the year, which wraps from 99 to 00.
- R10: The weekday advances by one on every day step and wraps from 6 to 0.
- R11: Codes 4 to 15 act like code 0: the register stays frozen and the running time keeps advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s | input | 1 | One-cycle pulse, once per second |
| ser_din | input | 1 | Serial data from host |
| ser_sclk | input | 1 | Serial shift clock from host |
| ser_stb | input | 1 | Command strobe from host |
| ser_dout | output | 1 | Serial data to host, register bit 0 |

## Verification
The hardest state to reach is a loaded time that sits on a month, year or leap boundary while the counter is still held. The register can only be loaded through the 52-place chain, and the set strobe needs the 4 command bits that finish the alignment. The bench writes whole time words through this path to load boundary dates: February 28 of leap and common years, 30-day months, and December 31 of year 99. It releases the hold with a separate command and counts seconds across the boundary. It then repeats this with constrained random times weighted toward the last second, minute, hour and day.

// File: rtl/sercal_pkg.sv
package sercal_pkg;

    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 6;
    localparam int TIME_W     = FIELD_W * NUM_FIELDS;
    localparam int CMD_W      = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_FREEZE = 4'd0,
        CMD_SHIFT  = 4'd1,
        CMD_LOAD   = 4'd2,
        CMD_COPY   = 4'd3
    } cmd_e;

    typedef struct packed {
        logic [7:0] year;
        logic [3:0] month;
        logic [3:0] wday;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_time_t;

    localparam cal_time_t TIME_RESET = '{year: 8'h00, month: 4'd1, wday: 4'd0,
                                         day: 8'h01, hour: 8'h00, min: 8'h00,
                                         sec: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic leap_bcd(input logic [7:0] y);
        if (y[4])
            return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] last_day_bcd(input logic [3:0] mon, input logic [7:0] y);
        case (mon)
            4'd2:                      return leap_bcd(y) ? 8'h29 : 8'h28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 8'h30;
            default:                   return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/sercal_edge.sv
module sercal_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise
);
    logic sig_q;

    // Reset to 1 so a line already high at reset release is not an edge.
    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b1;
        else     sig_q <= sig;
    end

    assign rise = sig && !sig_q;
endmodule

// File: rtl/sercal_chain.sv
module sercal_chain
    import sercal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    input  logic      sclk_rise,
    input  logic      stb_rise,
    input  cal_time_t now,
    output logic      dout,
    output logic      load,
    output cal_time_t load_val,
    output logic      hold_count
);
    logic [CMD_W-1:0]  cmd_sr;
    logic [CMD_W-1:0]  mode_q;
    logic [TIME_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_sr <= '0;
            mode_q <= CMD_FREEZE;
            data_q <= '0;
        end else if (stb_rise) begin
            mode_q <= cmd_sr;
            if (cmd_sr == CMD_COPY)
                data_q <= now;
        end else if (sclk_rise) begin
            cmd_sr <= {din, cmd_sr[CMD_W-1:1]};
            if (mode_q == CMD_SHIFT)
                data_q <= {cmd_sr[0], data_q[TIME_W-1:1]};
        end
    end

    assign dout       = data_q[0];
    assign load       = stb_rise && (cmd_sr == CMD_LOAD);
    assign load_val   = cal_time_t'(data_q);
    assign hold_count = (mode_q == CMD_LOAD);

    // R7
    frozen_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q != CMD_SHIFT && !stb_rise) |=> $stable(data_q));

    // R6
    set_hold_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> hold_count);

    // R2
    mode_change_chk: assert property (@(posedge clk) disable iff (rst)
        !stb_rise |=> $stable(mode_q));
endmodule

// File: rtl/sercal_counter.sv
module sercal_counter
    import sercal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      hold,
    input  logic      load,
    input  cal_time_t load_val,
    output cal_time_t now
);
    cal_time_t nxt;

    always_comb begin
        nxt = now;
        if (now.sec != 8'h59) begin
            nxt.sec = bcd_inc(now.sec);
        end else begin
            nxt.sec = 8'h00;
            if (now.min != 8'h59) begin
                nxt.min = bcd_inc(now.min);
            end else begin
                nxt.min = 8'h00;
                if (now.hour != 8'h23) begin
                    nxt.hour = bcd_inc(now.hour);
                end else begin
                    nxt.hour = 8'h00;
                    nxt.wday = (now.wday == 4'd6) ? 4'd0 : now.wday + 4'd1;
                    if (now.day != last_day_bcd(now.month, now.year)) begin
                        nxt.day = bcd_inc(now.day);
                    end else begin
                        nxt.day = 8'h01;
                        if (now.month != 4'd12) begin
                            nxt.month = now.month + 4'd1;
                        end else begin
                            nxt.month = 4'd1;
                            nxt.year  = (now.year == 8'h99) ? 8'h00 : bcd_inc(now.year);
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                now <= TIME_RESET;
        else if (load)          now <= load_val;
        else if (tick && !hold) now <= nxt;
    end

    // R6
    held_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && !load) |=> $stable(now));

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(now));

    // R8
    sec_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold && !load && now.sec != 8'h59) |=> (now.min == $past(now.min)));

    // R10
    wday_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold && !load) |=> (now.wday == $past(now.wday) || now.day == 8'h01
                                      || now.day == bcd_inc($past(now.day))));
endmodule

// File: rtl/serial_calendar.sv
module serial_calendar
    import sercal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_1s,
    input  logic ser_din,
    input  logic ser_sclk,
    input  logic ser_stb,
    output logic ser_dout
);
    logic      sclk_rise;
    logic      stb_rise;
    logic      load;
    logic      hold_count;
    cal_time_t load_val;
    cal_time_t now;

    sercal_edge i_sclk_edge (.clk(clk), .rst(rst), .sig(ser_sclk), .rise(sclk_rise));
    sercal_edge i_stb_edge  (.clk(clk), .rst(rst), .sig(ser_stb),  .rise(stb_rise));

    sercal_chain i_chain (
        .clk(clk), .rst(rst), .din(ser_din), .sclk_rise(sclk_rise),
        .stb_rise(stb_rise), .now(now), .dout(ser_dout), .load(load),
        .load_val(load_val), .hold_count(hold_count)
    );

    sercal_counter i_counter (
        .clk(clk), .rst(rst), .tick(tick_1s), .hold(hold_count),
        .load(load), .load_val(load_val), .now(now)
    );
endmodule

// File: tb/test_serial_calendar.sv
module test_serial_calendar;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_1s = 1'b0;
    logic ser_din = 1'b0;
    logic ser_sclk = 1'b0;
    logic ser_stb = 1'b0;
    logic ser_dout;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int m_s, m_mi, m_h, m_d, m_mo, m_wd, m_y;

    always #5 clk = ~clk;

    serial_calendar i_serial_calendar (
        .clk(clk), .rst(rst), .tick_1s(tick_1s), .ser_din(ser_din),
        .ser_sclk(ser_sclk), .ser_stb(ser_stb), .ser_dout(ser_dout)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int month_len(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [47:0] model_word();
        return {to_bcd(m_y), 4'(m_mo), 4'(m_wd), to_bcd(m_d), to_bcd(m_h),
                to_bcd(m_mi), to_bcd(m_s)};
    endfunction

    task automatic model_tick();
        m_s++;
        if (m_s == 60) begin m_s = 0; m_mi++; end
        if (m_mi == 60) begin m_mi = 0; m_h++; end
        if (m_h == 24) begin
            m_h = 0; m_d++; m_wd = (m_wd + 1) % 7;
            if (m_d > month_len(m_mo, m_y)) begin
                m_d = 1; m_mo++;
                if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
            end
        end
    endtask

    task automatic model_set(input int y, input int mo, input int wd, input int d,
                             input int h, input int mi, input int s);
        m_y = y; m_mo = mo; m_wd = wd; m_d = d; m_h = h; m_mi = mi; m_s = s;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_din = b;  wait_clk(3);
        ser_sclk = 1; wait_clk(3);
        ser_sclk = 0; wait_clk(3);
    endtask

    task automatic send_cmd(input logic [3:0] c);
        for (int i = 0; i < 4; i++) send_bit(c[i]);
        ser_stb = 1; wait_clk(3);
        ser_stb = 0; wait_clk(3);
    endtask

    task automatic shift_out(output logic [47:0] v);
        send_cmd(4'd1);
        for (int i = 0; i < 48; i++) begin
            v[i] = ser_dout;
            send_bit(1'b0);
        end
    endtask

    task automatic read_time(output logic [47:0] v);
        send_cmd(4'd3);
        shift_out(v);
    endtask

    task automatic write_time(input logic [47:0] v);
        send_cmd(4'd1);
        for (int i = 0; i < 48; i++) send_bit(v[i]);
        send_cmd(4'd2);
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1s = 1; wait_clk(1);
            tick_1s = 0; wait_clk(2);
        end
    endtask

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_model_and_run(input int n);
        write_time(model_word());
        send_cmd(4'd0);
        pulse_tick(n);
        for (int i = 0; i < n; i++) model_tick();
    endtask

    initial begin
        logic [47:0] got;
        logic [47:0] saved;
        void'($urandom(32'd2024));
        wait_clk(4);
        rst = 0;
        wait_clk(2);

        // R1: reset state
        chk("R1 dout", {47'd0, ser_dout}, 48'd0);
        model_set(0, 1, 0, 1, 0, 0, 0);
        read_time(got);
        chk("R1 R5 reset time", got, model_word());

        // R8: single second
        pulse_tick(1); model_tick();
        read_time(got);
        chk("R8 one second", got, model_word());

        // R8: no tick, no change
        wait_clk(30);
        read_time(got);
        chk("R8 idle", got, model_word());

        // R6: set holds counter until next strobe
        model_set(4, 2, 6, 28, 23, 59, 58);
        write_time(model_word());
        pulse_tick(3);
        read_time(got);
        chk("R6 set and hold", got, model_word());

        // R9 R10: leap February across midnight (read released hold)
        pulse_tick(2); model_tick(); model_tick();
        read_time(got);
        chk("R9 R10 leap day", got, model_word());

        // R9: end of year 99
        model_set(99, 12, 3, 31, 23, 59, 59);
        set_model_and_run(1);
        read_time(got);
        chk("R9 year wrap", got, model_word());

        // R9: common-year February
        model_set(3, 2, 6, 28, 23, 59, 59);
        set_model_and_run(1);
        read_time(got);
        chk("R9 common feb", got, model_word());

        // R9: 30-day month
        model_set(21, 4, 2, 30, 23, 59, 59);
        set_model_and_run(1);
        read_time(got);
        chk("R9 april end", got, model_word());

        // R10: weekday 6 wraps to 0
        model_set(50, 7, 6, 10, 23, 59, 59);
        set_model_and_run(1);
        read_time(got);
        chk("R10 weekday wrap", got, model_word());

        // R7: freeze mode ignores shift clocks
        send_cmd(4'd3);
        send_cmd(4'd0);
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        shift_out(got);
        chk("R7 freeze", got, model_word());

        // R11: unknown code freezes register, counter runs
        send_cmd(4'd3);
        saved = model_word();
        send_cmd(4'd9);
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        pulse_tick(1); model_tick();
        shift_out(got);
        chk("R11 register frozen", got, saved);
        read_time(got);
        chk("R11 counter runs", got, model_word());

        // R3 R4: first bit out equals seconds bit 0
        model_set(12, 9, 1, 15, 10, 20, 31);
        write_time(model_word());
        send_cmd(4'd3);
        send_cmd(4'd1);
        chk("R3 R4 first bit", {47'd0, ser_dout}, 48'd1);

        // R2 R8 R9 R10: random times near boundaries
        for (int it = 0; it < 16; it++) begin
            int y, mo, d, n;
            y  = $urandom % 100;
            mo = 1 + $urandom % 12;
            d  = ($urandom % 2 == 0) ? month_len(mo, y) : 1 + $urandom % month_len(mo, y);
            model_set(y, mo, $urandom % 7, d,
                      ($urandom % 2 == 0) ? 23 : $urandom % 24,
                      ($urandom % 2 == 0) ? 59 : $urandom % 60,
                      57 + $urandom % 3);
            n = 1 + $urandom % 3;
            set_model_and_run(n);
            read_time(got);
            chk("R2 R8 R9 R10 random", got, model_word());
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule